// File: doc/BRIEF.md
# Isolated Channel Link Output Supervisor

This block carries a small group of asynchronous digital channels (three to six) from an input side to an output side over a single serial wire and decides what the output pins show. The transmit half synchronises the channel inputs, takes a snapshot once per frame and sends frames back to back with no setup step. The receive half finds each frame, checks it, and latches the channel states. A supervisor state machine gates the latched values onto the output pins and drives the per-channel output enables.

Each side has its own supply-good flag and its own lockout. While the output side is in lockout, the outputs are undriven. When the output side leaves lockout, the outputs are held low for a startup interval before they follow the link. If no valid frame arrives within a loss-of-link window, the outputs drive a fail-safe level that a static strap selects. When frames come back, a fresh startup interval runs before tracking resumes. An active-high enable tri-states every output. A build parameter can remove the enable.

Supervisor states: OFF (output side in lockout), HOLD (startup interval), TRACK (following the link), SAFE (link lost, fail-safe level). Transitions: any state to OFF when `out_pwr_ok` is low; OFF to HOLD when `out_pwr_ok` is high; HOLD to TRACK at the end of the interval if the link is up, and HOLD to SAFE at that point if it is not; TRACK to SAFE when the link is lost; SAFE to HOLD when a valid frame arrives.

Receiver states: HUNT (waiting for the preamble), FIRST (first half of a bit pair), SECOND (second half of a bit pair, which is checked).

Top module: `iso_link_top`

## Requirements
- R1: Frame format and bit order:
  - A frame is three 1s, then a 0, then one complementary pair per channel in ascending channel order, then the parity pair.
  - A value b is sent as the pair (b, ~b).
  - With both sides powered and no configuration, `chan_out` settles to the value of `chan_in`.
- R2: The parity bit makes the count of ones across the channel bits and the parity bit even. The receiver leaves its latched values unchanged for any frame that fails parity or contains a pair that is not complementary.
- R3: One cycle after `out_pwr_ok` is low, `chan_oe` is all zero and `chan_out` is all zero. This also applies in reset.
- R4: After the output side leaves lockout, `chan_out` is driven low for STARTUP_CYC cycles. After that it follows the link.
- R5: One cycle after `in_pwr_ok` is low, `link_tx` is held at 0 and no frames are sent.
- R6: If no valid frame is received for LOSS_FRAMES frame periods, every `chan_out` bit equals `fs_default_hi`, where 1 means high. Shorter gaps keep the tracked values.
- R7: When the input side returns from lockout, `chan_out` stays low for the startup interval. After that it shows the current `chan_in`.
- R8: With HAS_ENABLE=1, `chan_oe` is all zero in the same cycle that `enable_in` is low. With `enable_in` high and the output side powered, `chan_oe` is all ones.
- R9: With HAS_ENABLE=0, `enable_in` has no effect and `chan_oe` stays all ones while the output side is powered.
- R10:
  - `chan_oe` is always either all zero or all ones.
  - The input side keeps sending frames while the output side is in lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| in_pwr_ok | input | 1 | Input-side supply good |
| out_pwr_ok | input | 1 | Output-side supply good |
| fs_default_hi | input | 1 | Static strap: fail-safe level is high when 1 |
| enable_in | input | 1 | Active-high output enable |
| chan_in | input | NCH | Asynchronous channel inputs |
| link_tx | output | 1 | Serial line from the transmit half |
| link_rx | input | 1 | Serial line into the receive half |
| chan_out | output | NCH | Output channel values |
| chan_oe | output | NCH | Per-channel output drive enable |

## Verification
A receiver that has lost frame alignment would latch a wrong value and show up as a stale or mixed `chan_out` within two frame periods of an input change. A timeout counter that does not clear would show up as an early fail-safe level within LOSS_FRAMES frames. A supervisor stuck in HOLD or SAFE would show up as `chan_out` low, or at the strap level, long after STARTUP_CYC has elapsed. Frames with bad parity or bad coding are injected directly onto the serial line, and `chan_out` is read right after each one, so that any wrongly accepted frame is visible at once.

// File: rtl/iso_link_pkg.sv
package iso_link_pkg;
    typedef enum logic [1:0] {SV_OFF, SV_HOLD, SV_TRACK, SV_SAFE} sv_state_t;
    typedef enum logic [1:0] {RX_HUNT, RX_FIRST, RX_SECOND} rx_state_t;
    typedef enum logic [1:0] {TX_IDLE, TX_PRE, TX_FIRST, TX_SECOND} tx_state_t;
    localparam int PRE_ONES = 3;
endpackage

// File: rtl/iso_link_tx.sv
module iso_link_tx #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_ok,
    input  logic [NCH-1:0] chan_in,
    output logic           line_o
);
    import iso_link_pkg::*;
    localparam int IW = $clog2(NCH + 1);

    tx_state_t      state;
    logic [NCH-1:0] sync1, sync2, snap;
    logic           par;
    logic [1:0]     pre_cnt;
    logic [IW-1:0]  pair_idx;
    logic           cur_bit;

    always_ff @(posedge clk) begin
        sync1 <= chan_in;
        sync2 <= sync1;
    end

    assign cur_bit = (pair_idx == IW'(NCH)) ? par : snap[pair_idx];

    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok) begin
            state    <= TX_IDLE;
            line_o   <= 1'b0;
            pre_cnt  <= '0;
            pair_idx <= '0;
            snap     <= '0;
            par      <= 1'b0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    state   <= TX_PRE;
                    pre_cnt <= '0;
                end
                TX_PRE: begin
                    if (pre_cnt < 2'(PRE_ONES)) begin
                        line_o  <= 1'b1;
                        pre_cnt <= pre_cnt + 2'd1;
                    end else begin
                        line_o   <= 1'b0;
                        snap     <= sync2;
                        par      <= ^sync2;
                        pair_idx <= '0;
                        state    <= TX_FIRST;
                    end
                end
                TX_FIRST: begin
                    line_o <= cur_bit;
                    state  <= TX_SECOND;
                end
                TX_SECOND: begin
                    line_o <= ~cur_bit;
                    if (pair_idx == IW'(NCH)) begin
                        state   <= TX_PRE;
                        pre_cnt <= '0;
                    end else begin
                        pair_idx <= pair_idx + IW'(1);
                        state    <= TX_FIRST;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/iso_link_rx.sv
module iso_link_rx #(
    parameter int NCH     = 6,
    parameter int TIMEOUT = 72
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_ok,
    input  logic           line_i,
    output logic [NCH-1:0] data_o,
    output logic           link_up_o
);
    import iso_link_pkg::*;
    localparam int IW = $clog2(NCH + 1);
    localparam int LW = $clog2(TIMEOUT + 1);

    rx_state_t      state;
    logic [1:0]     ones_q;
    logic           first_bit;
    logic [IW-1:0]  pair_idx;
    logic [NCH-1:0] shreg;
    logic [LW-1:0]  lost_cnt;

    assign link_up_o = (lost_cnt != LW'(TIMEOUT));

    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok) begin
            state     <= RX_HUNT;
            ones_q    <= '0;
            first_bit <= 1'b0;
            pair_idx  <= '0;
            shreg     <= '0;
            data_o    <= '0;
            lost_cnt  <= LW'(TIMEOUT);
        end else begin
            ones_q <= line_i ? ((ones_q == 2'(PRE_ONES)) ? ones_q : ones_q + 2'd1) : 2'd0;
            if (lost_cnt != LW'(TIMEOUT)) lost_cnt <= lost_cnt + LW'(1);
            unique case (state)
                RX_HUNT: begin
                    if (!line_i && ones_q == 2'(PRE_ONES)) begin
                        pair_idx <= '0;
                        state    <= RX_FIRST;
                    end
                end
                RX_FIRST: begin
                    first_bit <= line_i;
                    state     <= RX_SECOND;
                end
                RX_SECOND: begin
                    if (line_i == first_bit) begin
                        state <= RX_HUNT;
                    end else if (pair_idx == IW'(NCH)) begin
                        if (((^shreg) ^ first_bit) == 1'b0) begin
                            data_o   <= shreg;
                            lost_cnt <= '0;
                        end
                        state <= RX_HUNT;
                    end else begin
                        shreg[pair_idx] <= first_bit;
                        pair_idx        <= pair_idx + IW'(1);
                        state           <= RX_FIRST;
                    end
                end
                default: state <= RX_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/iso_link_supervisor.sv
module iso_link_supervisor #(
    parameter int NCH         = 6,
    parameter int STARTUP_CYC = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_ok,
    input  logic           link_up,
    input  logic [NCH-1:0] rx_data,
    input  logic           en_eff,
    input  logic           fs_high,
    output logic [NCH-1:0] chan_out,
    output logic [NCH-1:0] chan_oe
);
    import iso_link_pkg::*;
    localparam int HW = $clog2(STARTUP_CYC + 1);

    sv_state_t     state, nxt;
    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SV_OFF;
            hold_cnt <= '0;
        end else begin
            state    <= nxt;
            hold_cnt <= (state == SV_HOLD && nxt == SV_HOLD) ? hold_cnt + HW'(1) : '0;
        end
    end

    always_comb begin
        nxt = state;
        if (!pwr_ok) begin
            nxt = SV_OFF;
        end else begin
            unique case (state)
                SV_OFF:   nxt = SV_HOLD;
                SV_HOLD:  if (hold_cnt == HW'(STARTUP_CYC - 1)) nxt = link_up ? SV_TRACK : SV_SAFE;
                SV_TRACK: if (!link_up) nxt = SV_SAFE;
                SV_SAFE:  if (link_up) nxt = SV_HOLD;
                default:  nxt = SV_OFF;
            endcase
        end
    end

    always_comb begin
        chan_out = '0;
        chan_oe  = {NCH{en_eff}};
        unique case (state)
            SV_OFF:   chan_oe  = '0;
            SV_HOLD:  chan_out = '0;
            SV_TRACK: chan_out = rx_data;
            SV_SAFE:  chan_out = {NCH{fs_high}};
            default:  chan_oe  = '0;
        endcase
    end
endmodule

// File: rtl/iso_link_top.sv
module iso_link_top #(
    parameter int NCH         = 6,
    parameter int STARTUP_CYC = 64,
    parameter int LOSS_FRAMES = 4,
    parameter bit HAS_ENABLE  = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_pwr_ok,
    input  logic           out_pwr_ok,
    input  logic           fs_default_hi,
    input  logic           enable_in,
    input  logic [NCH-1:0] chan_in,
    output logic           link_tx,
    input  logic           link_rx,
    output logic [NCH-1:0] chan_out,
    output logic [NCH-1:0] chan_oe
);
    import iso_link_pkg::*;
    localparam int FRAME_LEN = PRE_ONES + 1 + 2 * (NCH + 1);
    localparam int TIMEOUT   = LOSS_FRAMES * FRAME_LEN;

    logic [NCH-1:0] rx_data;
    logic           link_up;
    logic           en_eff;

    generate
        if (HAS_ENABLE) begin : g_en
            assign en_eff = enable_in;
        end else begin : g_noen
            assign en_eff = enable_in | 1'b1;
        end
    endgenerate

    iso_link_tx #(.NCH(NCH)) tx_i (
        .clk(clk), .rst_n(rst_n), .pwr_ok(in_pwr_ok),
        .chan_in(chan_in), .line_o(link_tx)
    );

    iso_link_rx #(.NCH(NCH), .TIMEOUT(TIMEOUT)) rx_i (
        .clk(clk), .rst_n(rst_n), .pwr_ok(out_pwr_ok),
        .line_i(link_rx), .data_o(rx_data), .link_up_o(link_up)
    );

    iso_link_supervisor #(.NCH(NCH), .STARTUP_CYC(STARTUP_CYC)) sv_i (
        .clk(clk), .rst_n(rst_n), .pwr_ok(out_pwr_ok), .link_up(link_up),
        .rx_data(rx_data), .en_eff(en_eff), .fs_high(fs_default_hi),
        .chan_out(chan_out), .chan_oe(chan_oe)
    );
endmodule

// File: rtl/iso_link_chk.sv
module iso_link_chk #(
    parameter int NCH        = 6,
    parameter bit HAS_ENABLE = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_pwr_ok,
    input logic           out_pwr_ok,
    input logic           enable_in,
    input logic           link_tx,
    input logic [NCH-1:0] chan_out,
    input logic [NCH-1:0] chan_oe
);
    p_oe_off_lockout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_pwr_ok |=> (chan_oe == '0 && chan_out == '0));

    p_hold_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_pwr_ok) |=> (chan_out == '0));

    p_tx_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_pwr_ok |=> !link_tx);

    p_enable_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_ENABLE && !enable_in) |-> (chan_oe == '0));

    p_oe_uniform_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_oe == '0) || (chan_oe == '1));
endmodule

bind iso_link_top iso_link_chk #(.NCH(NCH), .HAS_ENABLE(HAS_ENABLE)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_pwr_ok(in_pwr_ok), .out_pwr_ok(out_pwr_ok),
    .enable_in(enable_in), .link_tx(link_tx), .chan_out(chan_out), .chan_oe(chan_oe)
);

// File: tb/iso_link_top_tb_top.sv
module iso_link_top_tb_top;
    localparam int NCH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_pwr_ok = 1'b1, out_pwr_ok = 1'b1, fs_hi = 1'b1, en = 1'b1;
    logic [NCH-1:0] chan_in = 6'h2D;
    logic inj_en = 1'b0, inj_bit = 1'b1;
    logic link_tx_a, link_rx_a, link_tx_b;
    logic [NCH-1:0] out_a, oe_a, out_b, oe_b;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign link_rx_a = inj_en ? inj_bit : link_tx_a;

    iso_link_top #(.NCH(NCH), .HAS_ENABLE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_pwr_ok(in_pwr_ok), .out_pwr_ok(out_pwr_ok),
        .fs_default_hi(fs_hi), .enable_in(en), .chan_in(chan_in), .link_tx(link_tx_a),
        .link_rx(link_rx_a), .chan_out(out_a), .chan_oe(oe_a));

    iso_link_top #(.NCH(NCH), .HAS_ENABLE(1'b0)) dut_noen_i (
        .clk(clk), .rst_n(rst_n), .in_pwr_ok(in_pwr_ok), .out_pwr_ok(out_pwr_ok),
        .fs_default_hi(fs_hi), .enable_in(en), .chan_in(chan_in), .link_tx(link_tx_b),
        .link_rx(link_tx_b), .chan_out(out_b), .chan_oe(oe_b));

    typedef struct {
        logic [NCH-1:0] out;
        logic [NCH-1:0] oe;
        bit             sel;
        string          tag;
    } exp_t;
    exp_t sb_q[$];

    // monitor: pops expected items and compares them away from the active edge
    always @(negedge clk) begin
        exp_t e;
        logic [NCH-1:0] got_out, got_oe;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            got_out = e.sel ? out_b : out_a;
            got_oe  = e.sel ? oe_b : oe_a;
            total++;
            if (got_out !== e.out || got_oe !== e.oe) begin
                bad++;
                $display("FAIL %s: out=%h oe=%h expected out=%h oe=%h",
                         e.tag, got_out, got_oe, e.out, e.oe);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_io(input logic [NCH-1:0] o, input logic [NCH-1:0] e, input bit sel, input string tag);
        exp_t it;
        it.out = o; it.oe = e; it.sel = sel; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic drive_bit(input logic b);
        inj_bit = b;
        @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input logic [NCH-1:0] d, input bit bad_par, input bit bad_code);
        logic p;
        p = (^d) ^ bad_par;
        inj_en = 1'b1;
        repeat (4) drive_bit(1'b1);
        drive_bit(1'b0);
        for (int i = 0; i < NCH; i++) begin
            drive_bit(d[i]);
            drive_bit((bad_code && i == 2) ? d[i] : ~d[i]);
        end
        drive_bit(p);
        drive_bit(~p);
        repeat (3) drive_bit(1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ones;
        int toggles;
        logic prev;
        cyc(3);
        expect_io('0, '0, 1'b0, "R3 reset state");
        rst_n = 1'b1;
        cyc(20);
        expect_io('0, '1, 1'b0, "R4 startup hold after reset");
        cyc(80);
        expect_io(6'h2D, '1, 1'b0, "R1 tracking 2D");
        expect_io(6'h2D, '1, 1'b1, "R1 tracking 2D no-enable build");
        chan_in = 6'h12; cyc(60);
        expect_io(6'h12, '1, 1'b0, "R1 tracking 12");
        chan_in = 6'h3F; cyc(60);
        expect_io(6'h3F, '1, 1'b0, "R1 tracking 3F");
        chan_in = 6'h00; cyc(60);
        expect_io(6'h00, '1, 1'b0, "R1 tracking 00");

        en = 1'b0; cyc(1);
        expect_io(6'h00, '0, 1'b0, "R8 enable low tri-state");
        expect_io(6'h00, '1, 1'b1, "R9 enable ignored");
        en = 1'b1; cyc(1);
        expect_io(6'h00, '1, 1'b0, "R8 enable high drives");

        send_frame(6'h15, 1'b0, 1'b0);
        expect_io(6'h15, '1, 1'b0, "R1 injected frame bit order");
        send_frame(6'h2A, 1'b1, 1'b0);
        expect_io(6'h15, '1, 1'b0, "R2 bad parity ignored");
        send_frame(6'h33, 1'b0, 1'b1);
        expect_io(6'h15, '1, 1'b0, "R2 bad pair ignored");
        inj_en = 1'b0;
        cyc(150);
        expect_io(6'h00, '1, 1'b0, "R1 link resumes");

        in_pwr_ok = 1'b0; cyc(2);
        ones = 0;
        for (int i = 0; i < 20; i++) begin
            if (link_tx_a) ones++;
            cyc(1);
        end
        check(ones == 0, "R5 line quiet in input lockout", ones, 0);
        cyc(100);
        expect_io('1, '1, 1'b0, "R6 fail-safe high");
        fs_hi = 1'b0; cyc(1);
        expect_io('0, '1, 1'b0, "R6 fail-safe low");
        fs_hi = 1'b1; cyc(1);

        chan_in = 6'h0B; in_pwr_ok = 1'b1;
        cyc(40);
        expect_io('0, '1, 1'b0, "R7 hold after input return");
        cyc(80);
        expect_io(6'h0B, '1, 1'b0, "R7 tracking after input return");

        out_pwr_ok = 1'b0; cyc(2);
        expect_io('0, '0, 1'b0, "R3 output lockout");
        toggles = 0;
        prev = link_tx_a;
        for (int i = 0; i < 20; i++) begin
            if (link_tx_a != prev) toggles++;
            prev = link_tx_a;
            cyc(1);
        end
        check(toggles > 0, "R10 frames continue in output lockout", toggles, 1);
        out_pwr_ok = 1'b1; cyc(20);
        expect_io('0, '1, 1'b0, "R4 hold after output return");
        cyc(100);
        expect_io(6'h0B, '1, 1'b0, "R4 tracking after hold");

        in_pwr_ok = 1'b0; cyc(20);
        expect_io(6'h0B, '1, 1'b0, "R6 short gap keeps values");
        cyc(120);
        expect_io('1, '1, 1'b0, "R6 fail-safe after timeout");
        in_pwr_ok = 1'b1;

        cyc(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule